// File: doc/BRIEF.md
# Reservation Station Array with Broadcast Wakeup

This block holds operations waiting in front of a single functional unit. An issue port delivers one operation per cycle together with two source operands. Each operand arrives either as a value or as a nonzero producer tag naming the unit that will compute it. A tag of zero means the value field already holds the operand. The accepted operation lands in a free station, and the block reports which station it took.

Every station with a missing operand watches one shared result bus. When the broadcast tag equals the station's pending tag, the station copies the broadcast data and clears that tag. A single broadcast can therefore release any number of waiting stations in the same cycle. An operand whose producer broadcasts in the very cycle of issue is taken straight from the bus, so that result is never missed.

A station whose two operands are both present is ready. Among the ready stations, the one issued earliest is offered to the functional unit. It leaves the array when the unit accepts it, and its station number becomes free for the next issue.

Each station is a small state machine with three states:
- `ST_FREE`: the station is empty.
- `ST_WAIT`: the station holds an operation and at least one operand is still missing.
- `ST_READY`: both operands are present.

The transitions are:
- issue-ready, from `ST_FREE` to `ST_READY`: issue with both operands present after any same-cycle capture.
- issue-wait, from `ST_FREE` to `ST_WAIT`: issue with an operand still missing.
- wakeup, from `ST_WAIT` to `ST_READY`: the last missing operand is captured from the bus.
- dispatch, from `ST_READY` to `ST_FREE`: the unit accepts the station.

Top module: `rs_array`

## Requirements
- R1: After reset every station is free: `iss_ready` is 1, `dsp_valid` is 0 and `iss_slot` is 0.
- R2: An operation issued with both tags equal to 0 is offered on the dispatch port (`dsp_valid` high) in the cycle after issue. It carries the issued op, value fields and immediate.
- R3: A waiting station captures `bc_data` into an operand only when `bc_valid` is high and `bc_tag` equals that operand's pending nonzero tag. A broadcast with any other tag leaves the station waiting and not dispatchable.
- R4: A station is never offered for dispatch while either operand is missing.
- R5: One broadcast releases every station waiting on its tag, in either operand position, in the same cycle.
- R6: If `bc_valid` is high and `bc_tag` matches an issuing operand's tag in the issue cycle, the operand is captured at issue. The station is then dispatchable in the next cycle if its other operand is present.
- R7: `iss_ready` is 0 exactly when all stations are busy. An issue attempt while `iss_ready` is 0 is dropped and creates no station.
- R8: When several stations are ready, the dispatch port shows the one issued earliest, whatever its station number.
- R9: A station leaves the array on a clock edge where `dsp_valid` and `fu_ready` are both 1, at most one per cycle. Its station number is free, and `iss_ready` is 1, from the next cycle.
- R10: `iss_slot` names the lowest-numbered free station, which the next accepted issue occupies. `dsp_slot` names the station being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_qj | input | TAG_W | Producer tag of operand A, 0 = value present |
| iss_vj | input | DATA_W | Value of operand A |
| iss_qk | input | TAG_W | Producer tag of operand B, 0 = value present |
| iss_vk | input | DATA_W | Value of operand B |
| iss_imm | input | IMM_W | Immediate / address field |
| iss_ready | output | 1 | A station is free |
| iss_slot | output | SLOT_W | Station the next issue occupies |
| bc_valid | input | 1 | Result bus valid |
| bc_tag | input | TAG_W | Result bus producer tag (nonzero) |
| bc_data | input | DATA_W | Result bus value |
| fu_ready | input | 1 | Functional unit accepts an operation |
| dsp_valid | output | 1 | A ready station is offered |
| dsp_op | output | OP_W | Offered operation code |
| dsp_a | output | DATA_W | Offered operand A |
| dsp_b | output | DATA_W | Offered operand B |
| dsp_imm | output | IMM_W | Offered immediate |
| dsp_slot | output | SLOT_W | Offered station number |

## Verification
The assertions take for granted that a broadcast never carries tag 0. They also assume that a producer tag is not broadcast again while an older consumer of the same tag is still waiting, since tags name in-flight producers. The bench uses only tags 1 to 7 on the bus, and each tag has at most one live meaning at a time. A tag sweep walks every pending tag against every non-matching broadcast before its own. The age ordering is exercised by refilling a low-numbered station while older, higher-numbered stations are still ready.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } rs_state_e;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              grant,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [IMM_W-1:0]  iss_imm,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk,
    output logic [IMM_W-1:0]  imm
);
    rs_state_e          state_r, state_nx;
    logic [OP_W-1:0]    op_r, op_nx;
    logic [IMM_W-1:0]   imm_r, imm_nx;
    logic [TAG_W-1:0]   qj_r, qj_nx, qk_r, qk_nx;
    logic [DATA_W-1:0]  vj_r, vj_nx, vk_r, vk_nx;
    logic               hit_j, hit_k, ihit_j, ihit_k;

    always_comb begin
        hit_j  = bc_valid && (qj_r != '0) && (qj_r == bc_tag);
        hit_k  = bc_valid && (qk_r != '0) && (qk_r == bc_tag);
        ihit_j = bc_valid && (iss_qj != '0) && (iss_qj == bc_tag);
        ihit_k = bc_valid && (iss_qk != '0) && (iss_qk == bc_tag);
    end

    always_comb begin
        state_nx = state_r;
        op_nx    = op_r;
        imm_nx   = imm_r;
        qj_nx    = qj_r;
        qk_nx    = qk_r;
        vj_nx    = vj_r;
        vk_nx    = vk_r;
        unique case (state_r)
            ST_FREE: begin
                if (alloc) begin
                    op_nx  = iss_op;
                    imm_nx = iss_imm;
                    qj_nx  = ihit_j ? '0 : iss_qj;
                    vj_nx  = ihit_j ? bc_data : iss_vj;
                    qk_nx  = ihit_k ? '0 : iss_qk;
                    vk_nx  = ihit_k ? bc_data : iss_vk;
                    state_nx = (qj_nx == '0 && qk_nx == '0) ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (hit_j) begin
                    qj_nx = '0;
                    vj_nx = bc_data;
                end
                if (hit_k) begin
                    qk_nx = '0;
                    vk_nx = bc_data;
                end
                if (qj_nx == '0 && qk_nx == '0) state_nx = ST_READY;
            end
            ST_READY: begin
                if (grant) state_nx = ST_FREE;
            end
            default: state_nx = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= ST_FREE;
            op_r    <= '0;
            imm_r   <= '0;
            qj_r    <= '0;
            qk_r    <= '0;
            vj_r    <= '0;
            vk_r    <= '0;
        end else begin
            state_r <= state_nx;
            op_r    <= op_nx;
            imm_r   <= imm_nx;
            qj_r    <= qj_nx;
            qk_r    <= qk_nx;
            vj_r    <= vj_nx;
            vk_r    <= vk_nx;
        end
    end

    always_comb begin
        busy  = (state_r != ST_FREE);
        ready = (state_r == ST_READY);
        op    = op_r;
        vj    = vj_r;
        vk    = vk_r;
        imm   = imm_r;
    end
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int NUM_ENT = 4,
    localparam int SLOT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] busy_vec,
    input  logic               iss_valid,
    output logic               any_free,
    output logic [SLOT_W-1:0]  free_idx,
    output logic [NUM_ENT-1:0] alloc_vec
);
    always_comb begin
        any_free = ~&busy_vec;
        free_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!busy_vec[i]) free_idx = SLOT_W'(i);
        end
        alloc_vec = '0;
        if (iss_valid && any_free) alloc_vec[free_idx] = 1'b1;
    end
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
    parameter int NUM_ENT = 4,
    localparam int SLOT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] alloc_vec,
    input  logic [NUM_ENT-1:0] ready_vec,
    input  logic               fu_ready,
    output logic [NUM_ENT-1:0] pick_vec,
    output logic [NUM_ENT-1:0] grant_vec,
    output logic [SLOT_W-1:0]  pick_idx
);
    // older_r[j][i] set: station j was issued before station i
    logic [NUM_ENT-1:0] older_r [NUM_ENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_ENT; j++) older_r[j] <= '0;
        end else begin
            for (int k = 0; k < NUM_ENT; k++) begin
                if (alloc_vec[k]) begin
                    for (int j = 0; j < NUM_ENT; j++) begin
                        older_r[k][j] <= 1'b0;
                        if (j != k) older_r[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            pick_vec[i] = ready_vec[i];
            for (int j = 0; j < NUM_ENT; j++) begin
                if (j != i && ready_vec[j] && older_r[j][i]) pick_vec[i] = 1'b0;
            end
        end
        grant_vec = fu_ready ? pick_vec : '0;
        pick_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (pick_vec[i]) pick_idx = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 16,
    parameter int OP_W    = 4,
    parameter int IMM_W   = 8,
    localparam int SLOT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [IMM_W-1:0]  iss_imm,
    output logic              iss_ready,
    output logic [SLOT_W-1:0] iss_slot,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic              fu_ready,
    output logic              dsp_valid,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b,
    output logic [IMM_W-1:0]  dsp_imm,
    output logic [SLOT_W-1:0] dsp_slot
);
    logic [NUM_ENT-1:0] busy_vec, ready_vec, alloc_vec, pick_vec, grant_vec;
    logic [OP_W-1:0]    ent_op  [NUM_ENT];
    logic [DATA_W-1:0]  ent_vj  [NUM_ENT];
    logic [DATA_W-1:0]  ent_vk  [NUM_ENT];
    logic [IMM_W-1:0]   ent_imm [NUM_ENT];

    rs_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
        .busy_vec (busy_vec),
        .iss_valid(iss_valid),
        .any_free (iss_ready),
        .free_idx (iss_slot),
        .alloc_vec(alloc_vec)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        rs_entry #(
            .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .IMM_W(IMM_W)
        ) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc   (alloc_vec[g]),
            .grant   (grant_vec[g]),
            .iss_op  (iss_op),
            .iss_qj  (iss_qj),
            .iss_vj  (iss_vj),
            .iss_qk  (iss_qk),
            .iss_vk  (iss_vk),
            .iss_imm (iss_imm),
            .bc_valid(bc_valid),
            .bc_tag  (bc_tag),
            .bc_data (bc_data),
            .busy    (busy_vec[g]),
            .ready   (ready_vec[g]),
            .op      (ent_op[g]),
            .vj      (ent_vj[g]),
            .vk      (ent_vk[g]),
            .imm     (ent_imm[g])
        );
    end

    rs_age_select #(.NUM_ENT(NUM_ENT)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_vec(alloc_vec),
        .ready_vec(ready_vec),
        .fu_ready (fu_ready),
        .pick_vec (pick_vec),
        .grant_vec(grant_vec),
        .pick_idx (dsp_slot)
    );

    always_comb begin
        dsp_valid = |ready_vec;
        dsp_op    = '0;
        dsp_a     = '0;
        dsp_b     = '0;
        dsp_imm   = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (pick_vec[i]) begin
                dsp_op  = dsp_op  | ent_op[i];
                dsp_a   = dsp_a   | ent_vj[i];
                dsp_b   = dsp_b   | ent_vk[i];
                dsp_imm = dsp_imm | ent_imm[i];
            end
        end
    end
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 3,
    localparam int SLOT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               iss_valid,
    input logic [TAG_W-1:0]   iss_qj,
    input logic [TAG_W-1:0]   iss_qk,
    input logic               iss_ready,
    input logic [SLOT_W-1:0]  iss_slot,
    input logic               fu_ready,
    input logic               dsp_valid,
    input logic [NUM_ENT-1:0] busy_vec,
    input logic [NUM_ENT-1:0] grant_vec
);
    assert_ready_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_qj == '0 && iss_qk == '0) |=> dsp_valid);

    assert_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (&busy_vec));

    assert_grant_only_accepted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_vec) |-> (fu_ready && dsp_valid));

    assert_one_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    assert_slot_freed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && fu_ready) |=> iss_ready);

    assert_slot_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> busy_vec[$past(iss_slot)]);
endmodule

bind rs_array rs_array_chk #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(iss_valid),
    .iss_qj   (iss_qj),
    .iss_qk   (iss_qk),
    .iss_ready(iss_ready),
    .iss_slot (iss_slot),
    .fu_ready (fu_ready),
    .dsp_valid(dsp_valid),
    .busy_vec (busy_vec),
    .grant_vec(grant_vec)
);

// File: tb/rs_array_test.sv
module rs_array_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic [2:0]  iss_qj = '0, iss_qk = '0;
    logic [15:0] iss_vj = '0, iss_vk = '0;
    logic [7:0]  iss_imm = '0;
    logic        iss_ready;
    logic [1:0]  iss_slot;
    logic        bc_valid = 1'b0;
    logic [2:0]  bc_tag = '0;
    logic [15:0] bc_data = '0;
    logic        fu_ready = 1'b0;
    logic        dsp_valid;
    logic [3:0]  dsp_op;
    logic [15:0] dsp_a, dsp_b;
    logic [7:0]  dsp_imm;
    logic [1:0]  dsp_slot;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    rs_array uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_qj(iss_qj), .iss_vj(iss_vj),
        .iss_qk(iss_qk), .iss_vk(iss_vk), .iss_imm(iss_imm),
        .iss_ready(iss_ready), .iss_slot(iss_slot),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .fu_ready(fu_ready),
        .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_a(dsp_a), .dsp_b(dsp_b),
        .dsp_imm(dsp_imm), .dsp_slot(dsp_slot)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input int op, input int qj, input int vj,
                         input int qk, input int vk, input int imm);
        iss_op = 4'(op); iss_qj = 3'(qj); iss_vj = 16'(vj);
        iss_qk = 3'(qk); iss_vk = 16'(vk); iss_imm = 8'(imm);
        iss_valid = 1'b1;
        step();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input int tag, input int data);
        bc_valid = 1'b1; bc_tag = 3'(tag); bc_data = 16'(data);
        step();
        bc_valid = 1'b0;
    endtask

    task automatic expect_dsp(input string req, input int slot, input int a, input int b);
        #1;
        chk({req, " dsp_valid"}, int'(dsp_valid), 1);
        chk({req, " dsp_slot"}, int'(dsp_slot), slot);
        chk({req, " dsp_a"}, int'(dsp_a), a);
        chk({req, " dsp_b"}, int'(dsp_b), b);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 iss_ready", int'(iss_ready), 1);
        chk("R1 dsp_valid", int'(dsp_valid), 0);
        chk("R1 iss_slot", int'(iss_slot), 0);

        // R2: ready-at-issue operation offered next cycle
        issue(1, 0, 10, 0, 20, 5);
        expect_dsp("R2", 0, 10, 20);
        chk("R2 dsp_op", int'(dsp_op), 1);
        chk("R2 dsp_imm", int'(dsp_imm), 5);
        chk("R10 iss_slot after one issue", int'(iss_slot), 1);

        issue(2, 5, 0, 0, 3, 0);      // slot1 waits tag5
        issue(3, 5, 0, 6, 0, 0);      // slot2 waits tag5, tag6
        issue(4, 0, 7, 0, 8, 0);      // slot3 ready
        chk("R7 full iss_ready", int'(iss_ready), 0);
        issue(9, 0, 99, 0, 99, 0);    // dropped
        chk("R7 still full", int'(iss_ready), 0);

        bcast(7, 70);                 // no station waits on 7
        chk("R3 oldest still slot0", int'(dsp_slot), 0);
        bcast(5, 55);                 // releases slot1, half of slot2

        fu_ready = 1'b1;
        expect_dsp("R8 first", 0, 10, 20);
        step();
        chk("R9 slot freed", int'(iss_ready), 1);
        chk("R10 freed slot reused", int'(iss_slot), 0);
        expect_dsp("R3 R5 capture", 1, 55, 3);
        step();
        expect_dsp("R8 third", 3, 7, 8);
        step();
        chk("R4 half-woken station held", int'(dsp_valid), 0);
        bcast(6, 66);
        expect_dsp("R5 second operand", 2, 55, 66);
        step();
        chk("R7 dropped issue never appears", int'(dsp_valid), 0);

        // R8: age order independent of station number
        fu_ready = 1'b0;
        issue(1, 0, 1, 0, 1, 0);      // slot0
        issue(1, 3, 0, 0, 2, 0);      // slot1 waits tag3
        issue(1, 0, 2, 0, 2, 0);      // slot2
        issue(1, 0, 3, 0, 3, 0);      // slot3
        fu_ready = 1'b1;
        expect_dsp("R8 oldest", 0, 1, 1);
        step();
        fu_ready = 1'b0;
        chk("R10 lowest free", int'(iss_slot), 0);
        issue(1, 0, 4, 0, 4, 0);      // youngest, in slot0
        fu_ready = 1'b1;
        expect_dsp("R8 older higher slot", 2, 2, 2);
        step();
        expect_dsp("R8 next older", 3, 3, 3);
        step();
        expect_dsp("R8 youngest last", 0, 4, 4);
        step();
        chk("R4 waiting not offered", int'(dsp_valid), 0);
        bcast(3, 33);
        expect_dsp("R3 wakeup", 1, 33, 2);
        step();

        // R6: same-cycle broadcast at issue, both operand positions
        fu_ready = 1'b0;
        bc_valid = 1'b1; bc_tag = 3'd4; bc_data = 16'd44;
        issue(5, 4, 0, 0, 9, 0);
        bc_tag = 3'd2; bc_data = 16'd22;
        issue(5, 0, 1, 2, 0, 0);
        bc_valid = 1'b0;
        expect_dsp("R6 operand A", 0, 44, 9);
        fu_ready = 1'b1;
        step();
        expect_dsp("R6 operand B", 1, 1, 22);
        step();
        fu_ready = 1'b0;

        // R3 sweep: every pending tag against every other broadcast tag
        for (int t = 1; t < 8; t++) begin
            issue(t, t, 0, 0, t, 0);
            for (int u = 1; u < 8; u++) begin
                if (u != t) begin
                    bcast(u, u + 100);
                    chk($sformatf("R3 tag %0d ignores %0d", t, u), int'(dsp_valid), 0);
                end
            end
            bcast(t, t * 11);
            expect_dsp($sformatf("R3 tag %0d match", t), 0, t * 11, t);
            fu_ready = 1'b1;
            step();
            fu_ready = 1'b0;
            chk("R9 drained", int'(iss_ready), 1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule